// File: doc/BRIEF.md
# Framebuffer Transfer Engine with RGBA-to-RGB Repacking

This block copies a rectangular image from one region of a byte-addressed memory to another. On the way it converts each 32-bit four-component source pixel into a packed three-byte destination pixel. Optionally, it halves the horizontal resolution by taking only every second source pixel. No filtering is applied.

Before starting a transfer, the surrounding logic presents the following on configuration inputs:
- the source and destination base addresses,
- the source line width in pixels,
- the destination width and height,
- the two format codes,
- the horizontal-halving flag.

It then writes the trigger register. The engine reads one source word per pixel and writes three destination bytes. When the last byte is written it raises a completion flag. An illegal format combination stops the engine before it touches memory and raises an error flag.

Top module: `dxfer_top`

## Requirements
- R1: A transfer is accepted only on a cycle where `trig_wr` is high and `trig_bit` is 1. A trigger write with `trig_bit` 0 causes no memory access and leaves `busy`, `done` and `err` unchanged.
- R2: A trigger write that arrives while `busy` is high is ignored. The transfer in progress finishes with its original configuration.
- R3: Pixels are handled in row-major order, one source read followed by three byte writes per pixel. A transfer of W×H pixels makes exactly W·H reads and 3·W·H writes.
- R4: Destination pixel (x, y) goes to byte addresses `dst_base + 3·(y·out_width + x) + k` for k = 0, 1, 2, written in that order.
- R5: Source pixel (x, y) is read at `src_base + 4·s·(x + y·in_width)`. The step s is 2 when `hscale` is 1 and 1 when `hscale` is 0.
- R6: Destination byte k equals source byte k (`rd_data[8k+7:8k]`, where the lowest address sits in bits 7:0) for k = 0, 1, 2. The fourth source byte (bits 31:24) is never written.
- R7: `busy` is high from the cycle after an accepted trigger until the final byte write. `done` rises at the clock edge that ends the final write, W·H·5 edges after the trigger edge. `done` then holds until the next accepted trigger clears it.
- R8: Source format code 0 (RGBA8) with destination code 1 (RGB8) is the only legal pair. Any other pair sets `err` at the trigger edge and makes no memory access, and `done` stays 0. An accepted trigger with a legal pair clears `err`.
- R9: A legal trigger with `out_width` or `out_height` equal to zero sets `done` at the trigger edge and makes no memory access.
- R10: Read data is taken from `rd_data` one cycle after `rd_req`. `rd_req` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_wr | input | 1 | Write strobe of the trigger register |
| trig_bit | input | 1 | Bit 0 of the value written to the trigger register |
| src_base | input | AW | Source byte base address |
| dst_base | input | AW | Destination byte base address |
| in_width | input | DIM_W | Source line width in pixels |
| out_width | input | DIM_W | Destination width in pixels |
| out_height | input | DIM_W | Destination height in rows |
| in_fmt | input | 3 | Source format code (0 = RGBA8) |
| out_fmt | input | 3 | Destination format code (1 = RGB8) |
| hscale | input | 1 | 1 = take every second source pixel |
| rd_req | output | 1 | Read request for one 32-bit word |
| rd_addr | output | AW | Byte address of the read |
| rd_data | input | 32 | Read data, valid one cycle after `rd_req` |
| wr_en | output | 1 | Byte write enable |
| wr_addr | output | AW | Byte address of the write |
| wr_data | output | 8 | Byte written |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer completed |
| err | output | 1 | Last trigger had an illegal format pair |

## Verification
The source region is filled with a byte pattern in which every neighbouring byte differs. A byte that is swapped, mis-addressed or taken from the alpha lane therefore shows up as a wrong destination value.

Every destination width and height from 1 to 3 is tried with both values of the halving flag. The source line width is set larger than the destination width, so a wrong row stride separates from a wrong column step. A guard byte past the destination region catches extra writes.

One run receives a second trigger with a different destination while it is busy. Separate runs cover:
- a trigger with bit 0 clear,
- each illegal format pair,
- zero width and zero height.

Together these separate ignored starts from aborted and empty ones.

// File: rtl/dxfer_pkg.sv
package dxfer_pkg;

    localparam int FMT_W = 3;
    localparam logic [FMT_W-1:0] FMT_RGBA8 = 3'd0;
    localparam logic [FMT_W-1:0] FMT_RGB8  = 3'd1;
    localparam int SRC_BYTES = 4;
    localparam int DST_BYTES = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_CAP,
        ST_WR0,
        ST_WR1,
        ST_WR2
    } xfer_state_e;

    typedef struct packed {
        logic [7:0] c2;
        logic [7:0] c1;
        logic [7:0] c0;
    } rgb_t;

    // lowest-address byte sits in bits 7:0; the top byte (alpha) is dropped
    function automatic rgb_t strip_alpha(input logic [31:0] w);
        rgb_t p;
        p.c0 = w[7:0];
        p.c1 = w[15:8];
        p.c2 = w[23:16];
        return p;
    endfunction

    function automatic logic [7:0] pick_byte(input rgb_t p, input logic [1:0] sel);
        logic [7:0] b;
        case (sel)
            2'd0:    b = p.c0;
            2'd1:    b = p.c1;
            default: b = p.c2;
        endcase
        return b;
    endfunction

    function automatic logic fmt_pair_ok(input logic [FMT_W-1:0] fi,
                                         input logic [FMT_W-1:0] fo);
        return (fi == FMT_RGBA8) && (fo == FMT_RGB8);
    endfunction

endpackage

// File: rtl/dxfer_addr_gen.sv
module dxfer_addr_gen
    import dxfer_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DIM_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    input  logic [AW-1:0]    src_base,
    input  logic [AW-1:0]    dst_base,
    input  logic [DIM_W-1:0] in_width,
    input  logic [DIM_W-1:0] out_width,
    input  logic [DIM_W-1:0] out_height,
    input  logic             hscale,
    output logic [AW-1:0]    src_addr,
    output logic [AW-1:0]    dst_addr,
    output logic             last
);

    localparam logic [AW-1:0] DST_STEP = AW'(DST_BYTES);

    logic [DIM_W-1:0] col_q, row_q, ow_q, oh_q;
    logic [AW-1:0]    src_row_q, src_px_q, dst_q, stride_q;
    logic             hs_q;
    logic [AW-1:0]    px_step;
    logic             row_end;
    logic [AW-1:0]    stride_ld;

    assign px_step   = hs_q ? AW'(2 * SRC_BYTES) : AW'(SRC_BYTES);
    assign row_end   = (col_q == ow_q - 1'b1);
    assign last      = row_end && (row_q == oh_q - 1'b1);
    assign stride_ld = hscale ? (AW'(in_width) << 3) : (AW'(in_width) << 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q     <= '0;
            row_q     <= '0;
            ow_q      <= '0;
            oh_q      <= '0;
            src_row_q <= '0;
            src_px_q  <= '0;
            dst_q     <= '0;
            stride_q  <= '0;
            hs_q      <= 1'b0;
        end else if (load) begin
            col_q     <= '0;
            row_q     <= '0;
            ow_q      <= out_width;
            oh_q      <= out_height;
            src_row_q <= src_base;
            src_px_q  <= src_base;
            dst_q     <= dst_base;
            stride_q  <= stride_ld;
            hs_q      <= hscale;
        end else if (adv) begin
            dst_q <= dst_q + DST_STEP;
            if (row_end) begin
                col_q     <= '0;
                row_q     <= row_q + 1'b1;
                src_row_q <= src_row_q + stride_q;
                src_px_q  <= src_row_q + stride_q;
            end else begin
                col_q    <= col_q + 1'b1;
                src_px_q <= src_px_q + px_step;
            end
        end
    end

    assign src_addr = src_px_q;
    assign dst_addr = dst_q;

    // R4: destination advances by one packed pixel per completed pixel
    a_r4_dst_advance: assert property (@(posedge clk) disable iff (rst)
        (adv && !last) |=> (dst_addr == $past(dst_addr) + DST_STEP));

    // R5: within a row the source advances by one (or two) source pixels
    a_r5_col_advance: assert property (@(posedge clk) disable iff (rst)
        (adv && !row_end) |=> (src_addr == $past(src_addr) + (hs_q ? AW'(8) : AW'(4))));

endmodule

// File: rtl/dxfer_pack.sv
module dxfer_pack
    import dxfer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cap,
    input  logic [31:0] rd_data,
    input  logic [1:0]  byte_sel,
    output logic [7:0]  wr_data
);

    rgb_t pix_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q <= '0;
        end else if (cap) begin
            pix_q <= strip_alpha(rd_data);
        end
    end

    assign wr_data = pick_byte(pix_q, byte_sel);

endmodule

// File: rtl/dxfer_ctrl.sv
module dxfer_ctrl
    import dxfer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       cfg_ok,
    input  logic       empty,
    input  logic       last,
    output logic       rd_req,
    output logic       cap,
    output logic       wr_en,
    output logic [1:0] byte_sel,
    output logic       adv,
    output logic       load,
    output logic       busy,
    output logic       done,
    output logic       err
);

    xfer_state_e state_q;
    logic        done_q, err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        done_q <= 1'b0;
                        err_q  <= 1'b0;
                        if (!cfg_ok) begin
                            err_q <= 1'b1;
                        end else if (empty) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= ST_RD;
                        end
                    end
                end
                ST_RD:  state_q <= ST_CAP;
                ST_CAP: state_q <= ST_WR0;
                ST_WR0: state_q <= ST_WR1;
                ST_WR1: state_q <= ST_WR2;
                ST_WR2: begin
                    if (last) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        state_q <= ST_RD;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        byte_sel = 2'd0;
        case (state_q)
            ST_WR1:  byte_sel = 2'd1;
            ST_WR2:  byte_sel = 2'd2;
            default: byte_sel = 2'd0;
        endcase
    end

    assign rd_req = (state_q == ST_RD);
    assign cap    = (state_q == ST_CAP);
    assign wr_en  = (state_q == ST_WR0) || (state_q == ST_WR1) || (state_q == ST_WR2);
    assign adv    = (state_q == ST_WR2);
    assign load   = (state_q == ST_IDLE) && start && cfg_ok && !empty;
    assign busy   = (state_q != ST_IDLE);
    assign done   = done_q;
    assign err    = err_q;

    // R8: an illegal format pair aborts at once with the error flag
    a_r8_bad_fmt: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !cfg_ok) |=> (err && !busy && !done));

    // R7: completion flag holds until a new start
    a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R2: while running neither status flag is set
    a_r2_busy_clean: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!done && !err));

endmodule

// File: rtl/dxfer_top.sv
module dxfer_top
    import dxfer_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DIM_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_wr,
    input  logic             trig_bit,
    input  logic [AW-1:0]    src_base,
    input  logic [AW-1:0]    dst_base,
    input  logic [DIM_W-1:0] in_width,
    input  logic [DIM_W-1:0] out_width,
    input  logic [DIM_W-1:0] out_height,
    input  logic [2:0]       in_fmt,
    input  logic [2:0]       out_fmt,
    input  logic             hscale,
    output logic             rd_req,
    output logic [AW-1:0]    rd_addr,
    input  logic [31:0]      rd_data,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [7:0]       wr_data,
    output logic             busy,
    output logic             done,
    output logic             err
);

    logic          start, cfg_ok, empty, last;
    logic          cap, adv, load;
    logic [1:0]    byte_sel;
    logic [AW-1:0] src_addr, dst_addr;

    assign start  = trig_wr && trig_bit;
    assign cfg_ok = fmt_pair_ok(in_fmt, out_fmt);
    assign empty  = (out_width == '0) || (out_height == '0);

    dxfer_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cfg_ok   (cfg_ok),
        .empty    (empty),
        .last     (last),
        .rd_req   (rd_req),
        .cap      (cap),
        .wr_en    (wr_en),
        .byte_sel (byte_sel),
        .adv      (adv),
        .load     (load),
        .busy     (busy),
        .done     (done),
        .err      (err)
    );

    dxfer_addr_gen #(.AW(AW), .DIM_W(DIM_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .adv        (adv),
        .src_base   (src_base),
        .dst_base   (dst_base),
        .in_width   (in_width),
        .out_width  (out_width),
        .out_height (out_height),
        .hscale     (hscale),
        .src_addr   (src_addr),
        .dst_addr   (dst_addr),
        .last       (last)
    );

    dxfer_pack u_pack (
        .clk      (clk),
        .rst      (rst),
        .cap      (cap),
        .rd_data  (rd_data),
        .byte_sel (byte_sel),
        .wr_data  (wr_data)
    );

    assign rd_addr = src_addr;
    assign wr_addr = dst_addr + AW'(byte_sel);

    // R10: reads are single-cycle requests, never back to back
    a_r10_read_gap: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    // R3: no memory write outside a running transfer
    a_r3_write_busy: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);

endmodule

// File: tb/dxfer_top_tb.sv
module dxfer_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 12;
    localparam int SRC_AT = 0;
    localparam int DST_AT = 512;
    localparam int ALT_AT = 768;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig_wr = 1'b0, trig_bit = 1'b0;
    logic [AW-1:0] src_base = '0, dst_base = '0;
    logic [DW-1:0] in_width = '0, out_width = '0, out_height = '0;
    logic [2:0]    in_fmt = 3'd0, out_fmt = 3'd1;
    logic          hscale = 1'b0;
    logic          rd_req, wr_en, busy, done, err;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [31:0]   rd_data = '0;
    logic [7:0]    wr_data;

    logic [7:0] mem [0:1023];
    int n_rd = 0, n_wr = 0;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dxfer_top #(.AW(AW), .DIM_W(DW)) dut_i (
        .clk(clk), .rst(rst), .trig_wr(trig_wr), .trig_bit(trig_bit),
        .src_base(src_base), .dst_base(dst_base), .in_width(in_width),
        .out_width(out_width), .out_height(out_height), .in_fmt(in_fmt),
        .out_fmt(out_fmt), .hscale(hscale), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .err(err)
    );

    always @(posedge clk) begin
        if (rd_req) begin
            rd_data <= {mem[(rd_addr[9:0] + 10'd3)], mem[(rd_addr[9:0] + 10'd2)],
                        mem[(rd_addr[9:0] + 10'd1)], mem[rd_addr[9:0]]};
            n_rd <= n_rd + 1;
        end
        if (wr_en) begin
            mem[wr_addr[9:0]] <= wr_data;
            n_wr <= n_wr + 1;
        end
    end

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic fill();
        for (int i = 0; i < 1024; i++) mem[i] = (i < DST_AT) ? pat(i) : 8'hEE;
    endtask

    task automatic pulse(input bit b);
        trig_wr = 1'b1; trig_bit = b;
        @(posedge clk);
        @(negedge clk);
        trig_wr = 1'b0; trig_bit = 1'b0;
    endtask

    task automatic run_xfer(input int ow, input int oh, input int hs, input bit inj);
        int iw, n, npx, rd0, wr0, step, sa, da;
        iw   = ow * (1 + hs) + 1;
        npx  = ow * oh;
        step = 4 * (1 + hs);
        fill();
        @(negedge clk);
        src_base = AW'(SRC_AT); dst_base = AW'(DST_AT);
        in_width = DW'(iw); out_width = DW'(ow); out_height = DW'(oh);
        in_fmt = 3'd0; out_fmt = 3'd1; hscale = hs[0];
        rd0 = n_rd; wr0 = n_wr;
        pulse(1'b1);
        chk(busy === 1'b1 && done === 1'b0, "R7 busy after trigger", int'(busy), 1);
        n = 1;
        while (!done && n < 2000) begin
            if (inj && n == 3) begin
                trig_wr = 1'b1; trig_bit = 1'b1;
                dst_base = AW'(ALT_AT); out_width = 1; out_height = 1;
            end else begin
                trig_wr = 1'b0; trig_bit = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            if (!done) n++;
        end
        trig_wr = 1'b0; trig_bit = 1'b0;
        chk(n == 5 * npx, "R7 cycles to done", n, 5 * npx);
        chk(busy === 1'b0, "R7 busy low at done", int'(busy), 0);
        chk(n_rd - rd0 == npx, "R3 read count", n_rd - rd0, npx);
        chk(n_wr - wr0 == 3 * npx, "R3 write count", n_wr - wr0, 3 * npx);
        for (int y = 0; y < oh; y++)
            for (int x = 0; x < ow; x++)
                for (int k = 0; k < 3; k++) begin
                    sa = SRC_AT + step * (x + y * iw) + k;
                    da = DST_AT + 3 * (y * ow + x) + k;
                    chk(mem[da] === pat(sa), "R4 R5 R6 pixel byte", int'(mem[da]), int'(pat(sa)));
                end
        chk(mem[DST_AT + 3 * npx] === 8'hEE, "R6 guard byte", int'(mem[DST_AT + 3 * npx]), 8'hEE);
        if (inj)
            chk(mem[ALT_AT] === 8'hEE, "R2 busy trigger ignored", int'(mem[ALT_AT]), 8'hEE);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(done === 1'b1, "R7 done holds", int'(done), 1);
    endtask

    task automatic idle_check(input string rq, input int rd0, input int wr0);
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk(n_rd == rd0 && n_wr == wr0, rq, n_wr - wr0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int rd0, wr0;
        fill();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R7 reset state", int'({busy, done, err}), 0);
        chk(rd_req === 1'b0 && wr_en === 1'b0, "R10 reset no access", int'({rd_req, wr_en}), 0);

        for (int hs = 0; hs < 2; hs++)
            for (int oh = 1; oh <= 3; oh++)
                for (int ow = 1; ow <= 3; ow++)
                    run_xfer(ow, oh, hs, (ow == 2 && oh == 2));

        // R1: trigger write with bit 0 clear
        out_width = 2; out_height = 2; in_width = 4;
        rd0 = n_rd; wr0 = n_wr;
        pulse(1'b0);
        chk(busy === 1'b0 && done === 1'b1, "R1 bit0 clear no start", int'({busy, done}), 1);
        idle_check("R1 bit0 clear no access", rd0, wr0);

        // R8: illegal source code
        in_fmt = 3'd2; out_fmt = 3'd1;
        rd0 = n_rd; wr0 = n_wr;
        pulse(1'b1);
        chk(err === 1'b1 && done === 1'b0 && busy === 1'b0, "R8 bad source fmt", int'({err, done, busy}), 4);
        idle_check("R8 bad source fmt no access", rd0, wr0);

        // R8: illegal destination code
        in_fmt = 3'd0; out_fmt = 3'd0;
        pulse(1'b1);
        chk(err === 1'b1 && done === 1'b0, "R8 bad dest fmt", int'({err, done}), 2);
        idle_check("R8 bad dest fmt no access", rd0, wr0);

        // R9: zero width, also clears err (R8)
        out_fmt = 3'd1; out_width = 0; out_height = 2;
        pulse(1'b1);
        chk(done === 1'b1 && err === 1'b0 && busy === 1'b0, "R9 zero width done R8 err clear", int'({done, err, busy}), 4);
        idle_check("R9 zero width no access", rd0, wr0);

        // R9: zero height
        out_width = 2; out_height = 0;
        pulse(1'b1);
        chk(done === 1'b1 && busy === 1'b0, "R9 zero height done", int'({done, busy}), 2);
        idle_check("R9 zero height no access", rd0, wr0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule